// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one channel that sits beside a free-running timer counter. In capture mode it watches a pin and records the counter value when the pin changes. In compare and PWM modes it drives an output pin from events reported by the counter. The counter value, its overflow, underflow and update strobes and its running flag all come from outside. The channel keeps its compare value and a buffer for it, and it outputs a pin level, a value register and a one-cycle event pulse.

The value register is shared between the modes. In capture mode it holds the last captured count. In compare and PWM modes it holds the active compare value. That value is loaded from a write buffer only on an update strobe, so software can change the compare point while the counter runs without causing a glitch. When the counter is stopped, the output goes to a configured rest level, and counting resumes from that level.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset, `ch_val` is 0, `evt_pulse` is 0 and `ch_out` equals `cfg_invert`.
- R2: `cfg_mode` encodes 0 = off, 1 = capture, 2 = compare, 3 = PWM. In off mode, pin edges and counter events change neither `ch_val` nor the output level, and `evt_pulse` stays 0.
- R3: `cfg_edge` encodes 0 = rising, 1 = falling, 2 = both and 3 = none. In capture mode, `pin_in` passes through two synchronizer flops, and a selected edge loads `ch_val` with `cnt_val` on the third rising clock edge after the pin changes. With 3 = none, no capture ever happens.
- R4: `cfg_evsel` encodes 0 = pulse on every capture, 1 = pulse on the 2nd, 4th, ... capture since capture mode was entered, 2 = pulse only on captures from a rising edge, and 3 = pulse only on captures from a falling edge. The pulse appears in the same cycle that `ch_val` is loaded.
- R5: In compare or PWM mode with `cnt_run` high, `cnt_val == ch_val` is a match. A match raises `evt_pulse` for one cycle, starting one clock later, whatever action is configured.
- R6: In compare mode, the underflow, overflow and match actions each use the encoding 0 = none, 1 = toggle, 2 = clear, 3 = set, and take effect one clock later. In one cycle, a match with an action other than none wins over overflow, and overflow wins over underflow.
- R7: In PWM mode, overflow sets the output and a match clears it. The configured actions are ignored, and a match wins over an overflow in the same cycle.
- R8: `buf_wr` stores `buf_data` in a buffer without changing `ch_val`. In compare or PWM mode, the next `cnt_upd` copies the buffer into `ch_val`, but only if the buffer was written since the previous update.
- R9: If a buffer write and an update fall in the same cycle, the update commits the earlier pending content, if any. The new data waits for a later update.
- R10: In compare or PWM mode, while `cnt_run` is low, the output level becomes `cfg_init_lvl` one clock later. When counting resumes, it continues from that level.
- R11: `cfg_invert` inverts `ch_out` combinationally in every mode. In off and capture modes, the level before inversion is 0.
- R12: While `cnt_run` is low, overflow, underflow and match have no effect on the output or on `evt_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Channel mode |
| cfg_edge | input | 2 | Capture edge select |
| cfg_evsel | input | 2 | Capture event select |
| cfg_act_ufl | input | 2 | Output action on underflow |
| cfg_act_ofl | input | 2 | Output action on overflow |
| cfg_act_match | input | 2 | Output action on match |
| cfg_init_lvl | input | 1 | Output level while the counter is stopped |
| cfg_invert | input | 1 | Invert the final output |
| cnt_val | input | CNT_W | Counter value |
| cnt_run | input | 1 | Counter is running |
| cnt_ofl | input | 1 | Counter overflow strobe |
| cnt_ufl | input | 1 | Counter underflow strobe |
| cnt_upd | input | 1 | Update strobe that commits the buffer |
| buf_wr | input | 1 | Compare buffer write |
| buf_data | input | CNT_W | Compare buffer data |
| pin_in | input | 1 | Asynchronous capture pin |
| ch_out | output | 1 | Channel output pin |
| ch_val | output | CNT_W | Captured count or active compare value |
| evt_pulse | output | 1 | One-cycle channel event |

## Verification
A capture result is due three clocks after the pin moves: two synchronizer flops, then the load. The bench holds `cnt_val` steady over that window. It checks after two clocks that nothing has happened yet, and after the third that `ch_val` and the pulse are correct. Compare, PWM, buffer commit and stop-level results are due one clock after the strobe that causes them, so every such stimulus is followed by exactly one clock before sampling. Inversion is combinational and is sampled a moment after it is driven, with no clock edge in between.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

   typedef enum logic [1:0] {
      CC_OFF     = 2'd0,
      CC_CAPTURE = 2'd1,
      CC_COMPARE = 2'd2,
      CC_PWM     = 2'd3
   } cc_mode_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_NONE = 2'd3
   } cc_edge_e;

   typedef enum logic [1:0] {
      EV_EVERY     = 2'd0,
      EV_SECOND    = 2'd1,
      EV_RISE_ONLY = 2'd2,
      EV_FALL_ONLY = 2'd3
   } cc_evsel_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } cc_act_e;

   // Level that results from applying one action to the present level.
   function automatic logic act_apply(cc_act_e a, logic cur);
      logic r;
      case (a)
         ACT_TOGGLE: r = ~cur;
         ACT_CLEAR:  r = 1'b0;
         ACT_SET:    r = 1'b1;
         default:    r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cc_pin_sync.sv
module cc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("cc_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], pin_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign rise = chain_q[LAST] & ~prev_q;
   assign fall = ~chain_q[LAST] & prev_q;

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/cc_capture_unit.sv
module cc_capture_unit import tmr_cc_pkg::*; (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  cc_edge_e  edge_sel,
   input  cc_evsel_e ev_sel,
   input  logic      rise,
   input  logic      fall,
   output logic      cap_load,
   output logic      cap_evt
);
   logic hit;
   logic parity_q;

   always_comb begin
      case (edge_sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   assign cap_load = enable & hit;

   // Counts captures modulo two since capture mode was entered.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        parity_q <= 1'b0;
      else if (!enable)  parity_q <= 1'b0;
      else if (cap_load) parity_q <= ~parity_q;
   end

   always_comb begin
      case (ev_sel)
         EV_EVERY:     cap_evt = cap_load;
         EV_SECOND:    cap_evt = cap_load & parity_q;
         EV_RISE_ONLY: cap_evt = cap_load & rise;
         default:      cap_evt = cap_load & fall;
      endcase
   end

   // R4
   second_evt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sel == EV_SECOND && cap_evt) |=> !(ev_sel == EV_SECOND && cap_evt));

   // R2
   evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !cap_evt);

endmodule

// File: rtl/cc_value_reg.sv
module cc_value_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_load,
   input  logic [W-1:0] cnt_val,
   input  logic         commit_en,
   input  logic         upd,
   input  logic         buf_wr,
   input  logic [W-1:0] buf_data,
   output logic [W-1:0] val_q
);
   localparam logic [W-1:0] VAL_RST = '0;

   logic [W-1:0] buf_q;
   logic         dirty_q;
   logic         commit;

   assign commit = commit_en & upd & dirty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q   <= VAL_RST;
         buf_q   <= VAL_RST;
         dirty_q <= 1'b0;
      end else begin
         if (cap_load)    val_q <= cnt_val;
         else if (commit) val_q <= buf_q;

         if (buf_wr) buf_q <= buf_data;

         if (buf_wr)                 dirty_q <= 1'b1;
         else if (commit_en && upd)  dirty_q <= 1'b0;
      end
   end

   // R8
   value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_load && !(commit_en && upd)) |=> $stable(val_q));

   // R3
   capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_load |=> (val_q == $past(cnt_val)));

   // R9
   fresh_write_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> dirty_q);

endmodule

// File: rtl/cc_output_unit.sv
module cc_output_unit import tmr_cc_pkg::*; #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cc_mode_e     mode,
   input  logic         run,
   input  logic         ofl,
   input  logic         ufl,
   input  logic [W-1:0] cnt_val,
   input  logic [W-1:0] cmp_val,
   input  cc_act_e      act_ufl,
   input  cc_act_e      act_ofl,
   input  cc_act_e      act_match,
   input  logic         init_lvl,
   output logic         lvl_q,
   output logic         match
);
   logic outmode;
   logic active;
   logic nxt;

   assign outmode = (mode == CC_COMPARE) || (mode == CC_PWM);
   assign active  = outmode & run;
   assign match   = active & (cnt_val == cmp_val);

   always_comb begin
      nxt = lvl_q;
      if (!active) begin
         nxt = init_lvl;
      end else if (mode == CC_PWM) begin
         if (match)    nxt = 1'b0;
         else if (ofl) nxt = 1'b1;
      end else begin
         if (match && act_match != ACT_NONE) nxt = act_apply(act_match, lvl_q);
         else if (ofl)                       nxt = act_apply(act_ofl, lvl_q);
         else if (ufl)                       nxt = act_apply(act_ufl, lvl_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= nxt;
   end

   // R10
   stopped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (lvl_q == $past(init_lvl)));

   // R7
   pwm_overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CC_PWM && run && ofl && !match) |=> lvl_q);

   // R7
   pwm_match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CC_PWM && match) |=> !lvl_q);

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel import tmr_cc_pkg::*; #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_edge,
   input  logic [1:0]       cfg_evsel,
   input  logic [1:0]       cfg_act_ufl,
   input  logic [1:0]       cfg_act_ofl,
   input  logic [1:0]       cfg_act_match,
   input  logic             cfg_init_lvl,
   input  logic             cfg_invert,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_run,
   input  logic             cnt_ofl,
   input  logic             cnt_ufl,
   input  logic             cnt_upd,
   input  logic             buf_wr,
   input  logic [CNT_W-1:0] buf_data,
   input  logic             pin_in,
   output logic             ch_out,
   output logic [CNT_W-1:0] ch_val,
   output logic             evt_pulse
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_width_chk
         $error("tmr_cc_channel: CNT_W must lie in 2..32");
      end
   endgenerate

   cc_mode_e mode;
   logic     outmode;
   logic     rise;
   logic     fall;
   logic     cap_load;
   logic     cap_evt;
   logic     lvl_q;
   logic     match;
   logic     evt_q;

   assign mode    = cc_mode_e'(cfg_mode);
   assign outmode = (mode == CC_COMPARE) || (mode == CC_PWM);

   cc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .rise   (rise),
      .fall   (fall)
   );

   cc_capture_unit u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (mode == CC_CAPTURE),
      .edge_sel (cc_edge_e'(cfg_edge)),
      .ev_sel   (cc_evsel_e'(cfg_evsel)),
      .rise     (rise),
      .fall     (fall),
      .cap_load (cap_load),
      .cap_evt  (cap_evt)
   );

   cc_value_reg #(.W(CNT_W)) u_val (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_load  (cap_load),
      .cnt_val   (cnt_val),
      .commit_en (outmode),
      .upd       (cnt_upd),
      .buf_wr    (buf_wr),
      .buf_data  (buf_data),
      .val_q     (ch_val)
   );

   cc_output_unit #(.W(CNT_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .run       (cnt_run),
      .ofl       (cnt_ofl),
      .ufl       (cnt_ufl),
      .cnt_val   (cnt_val),
      .cmp_val   (ch_val),
      .act_ufl   (cc_act_e'(cfg_act_ufl)),
      .act_ofl   (cc_act_e'(cfg_act_ofl)),
      .act_match (cc_act_e'(cfg_act_match)),
      .init_lvl  (cfg_init_lvl),
      .lvl_q     (lvl_q),
      .match     (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= cap_evt | match;
   end

   assign evt_pulse = evt_q;
   assign ch_out    = (outmode ? lvl_q : 1'b0) ^ cfg_invert;

   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CC_OFF) |=> !evt_pulse);

   // R12
   stopped_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_run && mode != CC_CAPTURE) |=> !evt_pulse);

endmodule

// File: tb/tmr_cc_channel_test.sv
module tmr_cc_channel_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  cfg_mode, cfg_edge, cfg_evsel;
   logic [1:0]  cfg_act_ufl, cfg_act_ofl, cfg_act_match;
   logic        cfg_init_lvl, cfg_invert;
   logic [15:0] cnt_val;
   logic        cnt_run, cnt_ofl, cnt_ufl, cnt_upd;
   logic        buf_wr;
   logic [15:0] buf_data;
   logic        pin_in;
   logic        ch_out;
   logic [15:0] ch_val;
   logic        evt_pulse;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_cc_channel uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_evsel(cfg_evsel),
      .cfg_act_ufl(cfg_act_ufl), .cfg_act_ofl(cfg_act_ofl), .cfg_act_match(cfg_act_match),
      .cfg_init_lvl(cfg_init_lvl), .cfg_invert(cfg_invert),
      .cnt_val(cnt_val), .cnt_run(cnt_run), .cnt_ofl(cnt_ofl), .cnt_ufl(cnt_ufl),
      .cnt_upd(cnt_upd), .buf_wr(buf_wr), .buf_data(buf_data), .pin_in(pin_in),
      .ch_out(ch_out), .ch_val(ch_val), .evt_pulse(evt_pulse)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   // Moves the pin and waits the three clocks a capture needs.
   task automatic pin_to(input logic v, input logic [15:0] c);
      cnt_val = c;
      pin_in  = v;
      tick(); tick(); tick();
   endtask

   task automatic t_reset();
      check("R1 ch_val", ch_val, 0);
      check("R1 evt", evt_pulse, 0);
      check("R1 out", ch_out, 0);
   endtask

   task automatic t_capture_edges();
      cfg_mode = 2'd1; cfg_edge = 2'd0; cfg_evsel = 2'd0;
      cnt_val = 16'd100; pin_in = 1'b1;
      tick(); tick();
      check("R3 not yet loaded", ch_val, 0);
      check("R3 no early evt", evt_pulse, 0);
      tick();
      check("R3 rise capture", ch_val, 100);
      check("R4 every evt", evt_pulse, 1);
      pin_to(1'b0, 16'd200);
      check("R3 fall ignored on rise", ch_val, 100);
      check("R3 no evt", evt_pulse, 0);
      cfg_edge = 2'd1;
      pin_to(1'b1, 16'd300);
      check("R3 rise ignored on fall", ch_val, 100);
      pin_to(1'b0, 16'd400);
      check("R3 fall capture", ch_val, 400);
      check("R3 fall evt", evt_pulse, 1);
      cfg_edge = 2'd3;
      pin_to(1'b1, 16'd500);
      check("R3 none rise", ch_val, 400);
      pin_to(1'b0, 16'd600);
      check("R3 none fall", ch_val, 400);
      check("R3 none evt", evt_pulse, 0);
   endtask

   task automatic t_events();
      cfg_mode = 2'd0; tick();
      cfg_mode = 2'd1; cfg_edge = 2'd2; cfg_evsel = 2'd1;
      pin_to(1'b1, 16'd10);
      check("R4 second: 1st val", ch_val, 10);
      check("R4 second: 1st no evt", evt_pulse, 0);
      pin_to(1'b0, 16'd20);
      check("R4 second: 2nd val", ch_val, 20);
      check("R4 second: 2nd evt", evt_pulse, 1);
      pin_to(1'b1, 16'd30);
      check("R4 second: 3rd no evt", evt_pulse, 0);
      pin_to(1'b0, 16'd40);
      check("R4 second: 4th evt", evt_pulse, 1);
      cfg_evsel = 2'd2;
      pin_to(1'b1, 16'd50);
      check("R4 rise-only val", ch_val, 50);
      check("R4 rise-only evt", evt_pulse, 1);
      pin_to(1'b0, 16'd60);
      check("R4 rise-only fall val", ch_val, 60);
      check("R4 rise-only fall no evt", evt_pulse, 0);
      cfg_evsel = 2'd3;
      pin_to(1'b1, 16'd70);
      check("R4 fall-only rise no evt", evt_pulse, 0);
      pin_to(1'b0, 16'd80);
      check("R4 fall-only val", ch_val, 80);
      check("R4 fall-only evt", evt_pulse, 1);
   endtask

   task automatic t_off();
      cfg_mode = 2'd0; cfg_edge = 2'd0; cfg_evsel = 2'd0;
      pin_to(1'b1, 16'd900);
      check("R2 off keeps value", ch_val, 80);
      check("R2 off no evt", evt_pulse, 0);
      cnt_run = 1'b1; cnt_val = 16'd80; cnt_ofl = 1'b1; cfg_act_ofl = 2'd3;
      tick();
      check("R2 off no match evt", evt_pulse, 0);
      check("R2 off out low", ch_out, 0);
      cnt_run = 1'b0; cnt_ofl = 1'b0; cfg_act_ofl = 2'd0;
      pin_to(1'b0, 16'd0);
   endtask

   task automatic t_buffer();
      cfg_mode = 2'd2;
      buf_wr = 1'b1; buf_data = 16'd5; tick(); buf_wr = 1'b0;
      check("R8 write alone", ch_val, 80);
      cnt_upd = 1'b1; tick(); cnt_upd = 1'b0;
      check("R8 commit", ch_val, 5);
      buf_data = 16'd77; cnt_upd = 1'b1; tick(); cnt_upd = 1'b0;
      check("R8 clean update", ch_val, 5);
      buf_wr = 1'b1; buf_data = 16'd11; tick();
      buf_data = 16'd12; cnt_upd = 1'b1; tick();
      buf_wr = 1'b0; cnt_upd = 1'b0;
      check("R9 commits earlier data", ch_val, 11);
      cnt_upd = 1'b1; tick(); cnt_upd = 1'b0;
      check("R9 later commit", ch_val, 12);
   endtask

   task automatic t_compare();
      cfg_act_match = 2'd1; cfg_init_lvl = 1'b0;
      cnt_run = 1'b1; cnt_val = 16'd3; tick();
      check("R5 no match", ch_out, 0);
      cnt_val = 16'd12; tick();
      check("R5 match evt", evt_pulse, 1);
      check("R6 toggle up", ch_out, 1);
      cnt_val = 16'd13; tick();
      check("R5 evt one cycle", evt_pulse, 0);
      cnt_val = 16'd12; tick();
      check("R6 toggle down", ch_out, 0);
      cfg_act_match = 2'd3; tick();
      check("R6 match set", ch_out, 1);
      cfg_act_match = 2'd2; tick();
      check("R6 match clear", ch_out, 0);
      cfg_act_match = 2'd0; tick();
      check("R5 evt with none", evt_pulse, 1);
      cnt_val = 16'd13; cfg_act_ofl = 2'd3; cnt_ofl = 1'b1; tick(); cnt_ofl = 1'b0;
      check("R6 ofl set", ch_out, 1);
      check("R6 ofl no evt", evt_pulse, 0);
      cfg_act_ufl = 2'd2; cnt_ufl = 1'b1; tick(); cnt_ufl = 1'b0;
      check("R6 ufl clear", ch_out, 0);
      cfg_act_ofl = 2'd1; cnt_ofl = 1'b1; tick();
      check("R6 ofl toggle up", ch_out, 1);
      tick(); cnt_ofl = 1'b0;
      check("R6 ofl toggle down", ch_out, 0);
      cfg_act_ofl = 2'd3; cfg_act_match = 2'd2; cnt_val = 16'd12; cnt_ofl = 1'b1; tick();
      check("R6 match beats ofl", ch_out, 0);
      cfg_act_match = 2'd0; tick(); cnt_ofl = 1'b0;
      check("R6 none match lets ofl act", ch_out, 1);
      cnt_val = 16'd13;
   endtask

   task automatic t_stop();
      cfg_act_ofl = 2'd3; cfg_act_match = 2'd1; cfg_init_lvl = 1'b0;
      cnt_run = 1'b0; tick();
      check("R10 stop to init 0", ch_out, 0);
      cnt_ofl = 1'b1; cnt_val = 16'd12; tick(); cnt_ofl = 1'b0;
      check("R12 ofl ignored", ch_out, 0);
      check("R12 match ignored", evt_pulse, 0);
      cfg_init_lvl = 1'b1; cnt_val = 16'd13; tick();
      check("R10 stop to init 1", ch_out, 1);
      cnt_run = 1'b1; tick();
      check("R10 resume level", ch_out, 1);
      cnt_val = 16'd12; tick();
      check("R10 resume toggles", ch_out, 0);
      cnt_val = 16'd13;
   endtask

   task automatic t_invert();
      cfg_invert = 1'b1; #1;
      check("R11 invert compare", ch_out, 1);
      cfg_mode = 2'd0; #1;
      check("R11 invert off", ch_out, 1);
      cfg_invert = 1'b0; #1;
      check("R11 plain off", ch_out, 0);
      cfg_mode = 2'd2;
      tick();
   endtask

   task automatic t_pwm();
      cfg_mode = 2'd3; cfg_init_lvl = 1'b0; cnt_run = 1'b0; tick();
      cfg_act_ofl = 2'd2; cfg_act_match = 2'd3;
      cnt_run = 1'b1; cnt_val = 16'd7; cnt_ofl = 1'b1; tick(); cnt_ofl = 1'b0;
      check("R7 ofl sets", ch_out, 1);
      cnt_val = 16'd8; tick();
      check("R7 holds", ch_out, 1);
      cnt_val = 16'd12; tick();
      check("R7 match clears", ch_out, 0);
      check("R5 pwm evt", evt_pulse, 1);
      cnt_val = 16'd12; cnt_ofl = 1'b1; tick();
      check("R7 match beats ofl", ch_out, 0);
      cnt_val = 16'd0; tick(); cnt_ofl = 1'b0;
      check("R7 ofl sets again", ch_out, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_mode = 2'd0; cfg_edge = 2'd0; cfg_evsel = 2'd0;
      cfg_act_ufl = 2'd0; cfg_act_ofl = 2'd0; cfg_act_match = 2'd0;
      cfg_init_lvl = 1'b0; cfg_invert = 1'b0;
      cnt_val = '0; cnt_run = 1'b0; cnt_ofl = 1'b0; cnt_ufl = 1'b0; cnt_upd = 1'b0;
      buf_wr = 1'b0; buf_data = '0; pin_in = 1'b0;
      tick(); tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_capture_edges();
      t_events();
      t_off();
      t_buffer();
      t_compare();
      t_stop();
      t_invert();
      t_pwm();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule